// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor

This block is a 32-bit processor core that completes one instruction on every rising clock edge. It has no pipeline. The core holds its program in a read-only instruction store, and the program is fixed when the core is elaborated through a parameter. The core also holds a word-wide data store and a 32-entry register file. It executes six instructions:

- register add and register subtract;
- OR with a zero-extended immediate;
- load word and store word;
- branch when two registers are equal.

Every other encoding does nothing except advance the program counter.

The only outside connections are clock and reset. The core also exposes the current program counter and the register write that the instruction now executing will commit. Because of this, a test environment can follow execution one instruction at a time without reaching into the core. There is no streaming data interface, so no valid/ready handshake appears, and every pin is a plain level signal.

Top module: `scpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and all registers and data words are cleared. `dbg_wr_en` stays low for as long as `rst` is high.
- R2: The instruction executed is the word at index (PC / 4) modulo the instruction store depth. Every instruction except a taken branch leaves PC + 4 as the next program counter.
- R3: The register format uses opcode 000000 in bits 31:26, source registers in bits 25:21 and 20:16, destination in bits 15:11, and function code in bits 5:0. Function 100000 writes first + second into the destination. Function 100010 writes first − second into the destination. Both wrap modulo 2^32.
- R4: Opcode 001101 writes (register 25:21) OR (bits 15:0 zero-extended) into register 20:16.
- R5: Opcode 100011 computes an address as (register 25:21) + (bits 15:0 sign-extended). It loads the data word at index (address / 4) modulo the data depth into register 20:16. Address bits 1:0 are ignored.
- R6: Opcode 101011 writes register 20:16 into the data word addressed as in R5 and writes no register.
- R7: Opcode 000100 compares registers 25:21 and 20:16. When they are equal, the next PC is PC + 4 + (sign-extended bits 15:0 × 4). When they differ, the next PC is PC + 4. No register is written.
- R8: Register 0 always reads as zero. A write aimed at it leaves it zero and keeps `dbg_wr_en` low.
- R9: An opcode outside the five above, or a register-format function code other than the two in R3, writes no register and no data word.
- R10: In the same cycle as the instruction that causes it, `dbg_wr_en`, `dbg_wr_addr` and `dbg_wr_data` describe the register write that is committed at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Address of the instruction now executing |
| dbg_wr_en | output | 1 | A register write commits at the next edge |
| dbg_wr_addr | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value of that write |

## Verification
The hardest cases to provoke from the pins are the ones that depend on earlier state:

- a taken branch that jumps backwards;
- a load that must return a value stored many instructions earlier, possibly through a different base register and offset that alias to the same word;
- a reset that lands in the middle of a program whose registers and memory already hold values.

The stimulus program starts with a directed prologue that covers zero and sign extension, wrap-around arithmetic, a write to register 0, a store followed by a load, a taken and an untaken branch, and two unsupported encodings. After the prologue comes a seeded pseudo-random body over a narrow register range and a small data store, so that values are reused and addresses collide often. The program closes with a branch back to address 0, so the body runs again and again on evolving state. A reset is inserted at a randomly chosen cycle.

// File: rtl/scpu_pkg.sv
package scpu_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREGS  = 1 << REG_AW;

  localparam logic [5:0] OPC_REG  = 6'b000000;
  localparam logic [5:0] OPC_ORI  = 6'b001101;
  localparam logic [5:0] OPC_LOAD = 6'b100011;
  localparam logic [5:0] OPC_STOR = 6'b101011;
  localparam logic [5:0] OPC_BEQ  = 6'b000100;
  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;

  typedef enum logic [2:0] {
    ALU_NONE = 3'b000,
    ALU_OR   = 3'b001,
    ALU_ADD  = 3'b010,
    ALU_SUB  = 3'b110
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;
    logic    src_imm;
    logic    load_sel;
    logic    sign_ext;
    logic    reg_we;
    logic    mem_we;
    logic    is_branch;
    logic    unsupported;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/scpu_ctrl.sv
module scpu_ctrl
  import scpu_pkg::*;
(
  input  logic [5:0] opc,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl             = '0;
    ctl.alu_op      = ALU_NONE;
    ctl.unsupported = 1'b1;
    unique case (opc)
      OPC_REG: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctl.unsupported = 1'b0;
          ctl.dst_rd      = 1'b1;
          ctl.reg_we      = 1'b1;
          ctl.alu_op      = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
        end
      end
      OPC_ORI: begin
        ctl.unsupported = 1'b0;
        ctl.src_imm     = 1'b1;
        ctl.reg_we      = 1'b1;
        ctl.alu_op      = ALU_OR;
      end
      OPC_LOAD: begin
        ctl.unsupported = 1'b0;
        ctl.src_imm     = 1'b1;
        ctl.sign_ext    = 1'b1;
        ctl.load_sel    = 1'b1;
        ctl.reg_we      = 1'b1;
        ctl.alu_op      = ALU_ADD;
      end
      OPC_STOR: begin
        ctl.unsupported = 1'b0;
        ctl.src_imm     = 1'b1;
        ctl.sign_ext    = 1'b1;
        ctl.mem_we      = 1'b1;
        ctl.alu_op      = ALU_ADD;
      end
      OPC_BEQ: begin
        ctl.unsupported = 1'b0;
        ctl.sign_ext    = 1'b1;
        ctl.is_branch   = 1'b1;
        ctl.alu_op      = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
  import scpu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_b
);
  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> regs[$past(wa)] == $past(wd)); // R3
  AST_R0_HELD: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0) |=> $stable(regs[0])); // R8
endmodule

// File: rtl/scpu_dmem.sv
module scpu_dmem #(
  parameter int W     = 32,
  parameter int WORDS = 16,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd
);
  logic [W-1:0] words [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) words[i] <= '0;
    end else if (we) begin
      words[idx] <= wd;
    end
  end

  assign rd = words[idx];

  AST_STORE_LANDS: assert property (@(posedge clk) disable iff (rst)
    we |=> words[$past(idx)] == $past(wd)); // R6
endmodule

// File: rtl/scpu_rom.sv
module scpu_rom #(
  parameter int                   WORDS = 64,
  parameter logic [WORDS*32-1:0]  INIT  = '0,
  localparam int                  IW    = $clog2(WORDS)
) (
  input  logic [IW-1:0] idx,
  output logic [31:0]   instr
);
  assign instr = INIT[{idx, 5'd0} +: 32];
endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scpu_pkg::*;
#(
  parameter int                       IMEM_WORDS = 64,
  parameter int                       DMEM_WORDS = 16,
  parameter logic [IMEM_WORDS*32-1:0] IMEM_INIT  = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-1:0]   dbg_pc,
  output logic              dbg_wr_en,
  output logic [REG_AW-1:0] dbg_wr_addr,
  output logic [XLEN-1:0]   dbg_wr_data
);
  localparam int IMW = $clog2(IMEM_WORDS);
  localparam int DMW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0]   pc_q, pc_plus4, br_target, pc_next;
  logic [31:0]       instr;
  ctrl_t             ctl;
  logic [REG_AW-1:0] f_rs, f_rt, f_rd, waddr;
  logic [15:0]       f_imm;
  logic [XLEN-1:0]   rs_val, rt_val, ext_imm, alu_b, alu_y, mem_rd, wdata;
  logic              alu_zero, take_branch, rf_we, dm_we;
  logic              unused_shamt;

  scpu_rom #(.WORDS(IMEM_WORDS), .INIT(IMEM_INIT)) u_rom (
    .idx(pc_q[IMW+1:2]), .instr(instr)
  );

  assign f_rs         = instr[25:21];
  assign f_rt         = instr[20:16];
  assign f_rd         = instr[15:11];
  assign f_imm        = instr[15:0];
  assign unused_shamt = ^instr[10:6];

  scpu_ctrl u_ctrl (.opc(instr[31:26]), .funct(instr[5:0]), .ctl(ctl));

  assign ext_imm = ctl.sign_ext ? {{(XLEN-16){f_imm[15]}}, f_imm}
                                : {{(XLEN-16){1'b0}}, f_imm};
  assign alu_b   = ctl.src_imm ? ext_imm : rt_val;
  assign waddr   = ctl.dst_rd ? f_rd : f_rt;
  assign wdata   = ctl.load_sel ? mem_rd : alu_y;
  assign rf_we   = ctl.reg_we && !rst;
  assign dm_we   = ctl.mem_we && !rst;

  scpu_regfile #(.W(XLEN), .DEPTH(NREGS)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .wa(waddr), .wd(wdata),
    .ra_a(f_rs), .rd_a(rs_val), .ra_b(f_rt), .rd_b(rt_val)
  );

  scpu_alu #(.W(XLEN)) u_alu (
    .a(rs_val), .b(alu_b), .op(ctl.alu_op), .y(alu_y), .zero(alu_zero)
  );

  scpu_dmem #(.W(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
    .clk(clk), .rst(rst), .we(dm_we), .idx(alu_y[DMW+1:2]),
    .wd(rt_val), .rd(mem_rd)
  );

  assign pc_plus4    = pc_q + XLEN'(4);
  assign br_target   = pc_plus4 + {ext_imm[XLEN-3:0], 2'b00};
  assign take_branch = ctl.is_branch && alu_zero;
  assign pc_next     = take_branch ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign dbg_pc      = pc_q;
  assign dbg_wr_en   = rf_we && (waddr != '0);
  assign dbg_wr_addr = waddr;
  assign dbg_wr_data = wdata;

  AST_PC_ON_RESET: assert property (@(posedge clk)
    rst |=> pc_q == '0); // R1
  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    !take_branch |=> pc_q == $past(pc_q) + XLEN'(4)); // R2
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    take_branch |=> pc_q == $past(pc_q) + XLEN'(4) + {$past(ext_imm[XLEN-3:0]), 2'b00}); // R7
  AST_NOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    ctl.unsupported |-> !rf_we && !dm_we && !take_branch); // R9
  AST_R0_SILENT: assert property (@(posedge clk) disable iff (rst)
    (waddr == '0) |-> !dbg_wr_en); // R8
endmodule

// File: tb/tb_scpu_core.sv
`timescale 1ns/1ps
module tb_scpu_core;
  localparam int IW = 64;
  localparam int DW = 16;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [IW*32-1:0] build_prog();
    logic [IW*32-1:0] p;
    logic [31:0] w [IW];
    logic [31:0] s;
    int kind, ra, rb, rc, off;
    s = 32'h1357_2468;
    w[0]  = enc_i(6'b001101, 0, 1, 16'h8001);
    w[1]  = enc_i(6'b001101, 0, 2, 16'hFFFF);
    w[2]  = enc_r(0, 1, 3, 6'b100010);
    w[3]  = enc_r(3, 3, 4, 6'b100000);
    w[4]  = enc_i(6'b001101, 1, 0, 16'h1234);
    w[5]  = enc_r(0, 0, 5, 6'b100000);
    w[6]  = enc_i(6'b101011, 1, 3, 16'h0000);
    w[7]  = enc_i(6'b100011, 1, 6, 16'h0000);
    w[8]  = enc_i(6'b100011, 1, 7, 16'hFFF8);
    w[9]  = enc_i(6'b000100, 1, 1, 16'h0001);
    w[10] = enc_i(6'b001101, 0, 6, 16'hDEAD);
    w[11] = enc_i(6'b000100, 1, 2, 16'h0005);
    w[12] = 32'hFC00_1234;
    w[13] = enc_r(1, 2, 4, 6'b100101);
    for (int i = 14; i < IW - 1; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      kind = int'((s >> 16) % 8);
      ra = int'((s >> 3) % 8);
      rb = int'((s >> 7) % 8);
      rc = int'((s >> 11) % 8);
      off = int'((s >> 20) % 3);
      if (i + 1 + off > IW - 2) off = 0;
      case (kind)
        0, 7: w[i] = enc_r(ra, rb, rc, 6'b100000);
        1:    w[i] = enc_r(ra, rb, rc, 6'b100010);
        2:    w[i] = enc_i(6'b001101, ra, rb, s[31:16]);
        3:    w[i] = enc_i(6'b100011, ra, rb, s[27:12]);
        4:    w[i] = enc_i(6'b101011, ra, rb, s[29:14]);
        5:    w[i] = enc_i(6'b000100, ra, rb, 16'(off));
        default: w[i] = {3'b110, s[2:0], s[25:0]};
      endcase
    end
    w[IW-1] = enc_i(6'b000100, 0, 0, 16'hFFC0);
    for (int i = 0; i < IW; i++) p[i*32 +: 32] = w[i];
    return p;
  endfunction

  localparam logic [IW*32-1:0] PROG = build_prog();

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_addr;
  logic [31:0] dbg_wr_data;

  always #2.5 clk = ~clk;

  scpu_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW), .IMEM_INIT(PROG)) dut (
    .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
    .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] m_pc;
  logic [31:0] m_regs [32];
  logic [31:0] m_mem [DW];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (pc model %h)", req, act, exp, m_pc);
    end
  endtask

  task automatic model_reset();
    m_pc = '0;
    for (int i = 0; i < 32; i++) m_regs[i] = '0;
    for (int i = 0; i < DW; i++) m_mem[i] = '0;
  endtask

  task automatic step_and_check();
    logic [31:0] ins, a, b, sx, zx, addr, npc, wd;
    logic [4:0]  wa;
    logic        we, mwe;
    string       req;
    ins  = PROG[m_pc[7:2]*32 +: 32];
    a    = m_regs[ins[25:21]];
    b    = m_regs[ins[20:16]];
    sx   = {{16{ins[15]}}, ins[15:0]};
    zx   = {16'd0, ins[15:0]};
    addr = a + sx;
    npc  = m_pc + 32'd4;
    we = 0; mwe = 0; wa = '0; wd = '0; req = "R9";
    case (ins[31:26])
      6'b000000: begin
        if (ins[5:0] == 6'b100000) begin we = 1; wa = ins[15:11]; wd = a + b; req = "R3"; end
        else if (ins[5:0] == 6'b100010) begin we = 1; wa = ins[15:11]; wd = a - b; req = "R3"; end
      end
      6'b001101: begin we = 1; wa = ins[20:16]; wd = a | zx; req = "R4"; end
      6'b100011: begin we = 1; wa = ins[20:16]; wd = m_mem[addr[5:2]]; req = "R5"; end
      6'b101011: begin mwe = 1; req = "R6"; end
      6'b000100: begin req = "R7"; if (a == b) npc = m_pc + 32'd4 + {sx[29:0], 2'b00}; end
      default: req = "R9";
    endcase
    if (we && wa == 5'd0) begin we = 0; req = "R8"; end
    chk({req, "/R2 pc"}, dbg_pc, m_pc);
    chk({req, "/R10 wr_en"}, {31'd0, dbg_wr_en}, {31'd0, we});
    if (we) begin
      chk({req, "/R10 wr_addr"}, {27'd0, dbg_wr_addr}, {27'd0, wa});
      chk({req, " wr_data"}, dbg_wr_data, wd);
    end
    if (we) m_regs[wa] = wd;
    if (mwe) m_mem[addr[5:2]] = b;
    m_pc = npc;
  endtask

  initial begin
    int seed_v, rst_at, rst_len;
    seed_v  = $urandom(32'd4242);
    rst_at  = 400 + int'($urandom % 1200);
    rst_len = 1 + int'($urandom % 3);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc after reset", dbg_pc, 32'd0);
    chk("R1 wr_en in reset", {31'd0, dbg_wr_en}, 32'd0);
    rst = 1'b0;
    #1;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (cyc == rst_at) begin
        rst = 1'b1;
        #1;
        chk("R1 wr_en held low", {31'd0, dbg_wr_en}, 32'd0);
        repeat (rst_len) @(posedge clk);
        @(negedge clk);
        chk("R1 pc mid-run reset", dbg_pc, 32'd0);
        model_reset();
        rst = 1'b0;
        #1;
      end
      step_and_check();
      @(negedge clk);
      #1;
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule